// File: doc/BRIEF.md
# Link Start Speed-Cap Controller

This block runs the start-of-training sequence for a PCI Express port whose core sits behind a simple configuration read/write port. On a start request it unlocks writes to normally read-only configuration registers. It reads the link capabilities word and remembers its supported-link-speed field. It then writes the word back with that field forced to the 2.5 GT/s code, enables the link training state machine and waits for link-up.

Once the link is up, the capabilities word is read again. If the field no longer matches the remembered value, the original value is written back. The block then sets the directed speed-change bit in the port-logic link width/speed control register and waits for link-up a second time. Every exit path, successful or failed, locks the read-only registers again. The end is marked by a single `done_o` pulse, with `err_o` and a reason code when a link-up wait timed out.

Top module: `link_speed_cap_ctrl`

## Requirements
- R1: After reset `cfg_req_o`, `ro_wr_en_o`, `ltssm_en_o`, `busy_o`, `done_o` and `err_o` are 0 and `err_code_o` is 0.
- R2: `ro_wr_en_o` rises before the first configuration access of a sequence and is high whenever a configuration write is requested. It falls in the same cycle that `done_o` pulses, on every exit path.
- R3: The first access of a sequence reads `CAP_ADDR`. The second writes `CAP_ADDR` with the data read, except that bits [3:0] (the speed field) are replaced by 4'h1, the 2.5 GT/s code.
- R4: `ltssm_en_o` stays 0 until the forced-speed write has completed. It then goes to 1 and holds at 1 until reset.
- R5: If `link_up_i` is not seen high within `TIMEOUT` cycles of the first wait, the sequence ends with `err_code_o` = 1 and makes no further configuration access.
- R6: After the first link-up, `CAP_ADDR` is read again. If its bits [3:0] equal the saved field, the sequence ends without error and makes no further access.
- R7: If they differ, `CAP_ADDR` is written with the second read's data and the saved field in bits [3:0]. Then `CTL_ADDR` is read and written back with bit `SPD_BIT` (default 17) set.
- R8: After the speed-change write the block waits for `link_up_i` again. A timeout ends the sequence with `err_code_o` = 2, and success ends it with code 0.
- R9: Configuration accesses are single-outstanding. `cfg_req_o`, `cfg_we_o`, `cfg_addr_o` and `cfg_wdata_o` hold steady until `cfg_ready_i`, and read data is taken in the ready cycle.
- R10: `done_o` is a one-cycle pulse, once per sequence. `err_o` pulses only with `done_o`, and `err_code_o` holds the result from then until the next start.
- R11: `start_i` while `busy_o` is high is ignored: no extra accesses and no extra `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start the sequence (taken when idle) |
| cfg_req_o | output | 1 | Configuration access request |
| cfg_we_o | output | 1 | 1 = write, 0 = read |
| cfg_addr_o | output | AW | Configuration register address |
| cfg_wdata_o | output | DW | Write data |
| cfg_ready_i | input | 1 | Access complete; read data valid |
| cfg_rdata_i | input | DW | Read data |
| ro_wr_en_o | output | 1 | Unlock writes to read-only registers |
| ltssm_en_o | output | 1 | Link training state machine enable |
| link_up_i | input | 1 | Link is up |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | End-of-sequence pulse |
| err_o | output | 1 | Error pulse, with done_o |
| err_code_o | output | 2 | 0 ok, 1 first wait timed out, 2 second wait timed out |

## Verification
The assertions watch, on every cycle, the request-hold rule of the configuration handshake and that writes only happen while registers are unlocked. They also check that locking coincides with the done pulse, that errors appear only with done, and that training enable, once raised, stays raised. Which accesses occur, their data, the comparison of the re-read speed field against the saved one, and the choice among the three end codes can only be shown by the bench's scenarios. The bench drives several speed fields, handshake latencies and link-up outcomes against a model of the configuration space.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int FLD_W = 4;
  localparam logic [FLD_W-1:0] SPD_2G5 = 4'h1;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_TRAIN   = 2'd1,
    ERR_RETRAIN = 2'd2
  } err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_OPEN, S_RD_CAP, S_WR_CAP, S_TRAIN, S_WAIT1,
    S_RD_CHK, S_WR_RST, S_RD_CTL, S_WR_CTL, S_WAIT2, S_CLOSE
  } state_e;
endpackage

// File: rtl/lsc_cfg_port.sv
module lsc_cfg_port #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic          cmd_we_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          cfg_req_o,
  output logic          cfg_we_o,
  output logic [AW-1:0] cfg_addr_o,
  output logic [DW-1:0] cfg_wdata_o,
  input  logic          cfg_ready_i,
  input  logic [DW-1:0] cfg_rdata_i
);
  logic          req_q, we_q, rsp_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      if (req_q) begin
        if (cfg_ready_i) begin
          req_q   <= 1'b0;
          rsp_q   <= 1'b1;
          rdata_q <= cfg_rdata_i;
        end
      end else if (cmd_valid_i) begin
        req_q   <= 1'b1;
        we_q    <= cmd_we_i;
        addr_q  <= cmd_addr_i;
        wdata_q <= cmd_wdata_i;
      end
    end
  end

  assign cfg_req_o   = req_q;
  assign cfg_we_o    = we_q;
  assign cfg_addr_o  = addr_q;
  assign cfg_wdata_o = wdata_q;
  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rdata_q;

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && !cfg_ready_i |=> cfg_req_o && $stable(cfg_we_o) &&
      $stable(cfg_addr_o) && $stable(cfg_wdata_o));

  // R9
  rsp_after_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && cfg_ready_i |=> rsp_valid_o && !cfg_req_o);
endmodule

// File: rtl/lsc_link_wait.sv
module lsc_link_wait #(
  parameter int TIMEOUT = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic link_up_i,
  output logic up_o,
  output logic expired_o
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!en_i)                   cnt_q <= '0;
    else if (!link_up_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign up_o      = en_i && link_up_i;
  assign expired_o = en_i && !link_up_i && (cnt_q == LAST);

  // R5
  wait_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/lsc_seq.sv
module lsc_seq
  import lsc_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter logic [AW-1:0] CAP_ADDR = 12'h07C,
  parameter logic [AW-1:0] CTL_ADDR = 12'h80C,
  parameter int SPD_BIT = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_rdata_i,
  input  logic          up_i,
  input  logic          expired_i,
  output logic          cmd_valid_o,
  output logic          cmd_we_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [DW-1:0] cmd_wdata_o,
  output logic          wait_en_o,
  output logic          ro_wr_en_o,
  output logic          ltssm_en_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [1:0]    err_code_o
);
  localparam logic [DW-1:0] SPD_MASK = DW'(1) << SPD_BIT;

  state_e           state_q;
  logic             pend_q, unlock_q, ltssm_q, done_q, err_q;
  logic [FLD_W-1:0] saved_q;
  logic [DW-1:0]    word_q;
  err_e             code_q, res_q;
  logic             access;

  always_comb begin
    access = 1'b0;
    cmd_we_o = 1'b0;
    cmd_addr_o = CAP_ADDR;
    cmd_wdata_o = '0;
    unique case (state_q)
      S_RD_CAP, S_RD_CHK: access = 1'b1;
      S_WR_CAP: begin
        access = 1'b1; cmd_we_o = 1'b1;
        cmd_wdata_o = {word_q[DW-1:FLD_W], SPD_2G5};
      end
      S_WR_RST: begin
        access = 1'b1; cmd_we_o = 1'b1;
        cmd_wdata_o = {word_q[DW-1:FLD_W], saved_q};
      end
      S_RD_CTL: begin access = 1'b1; cmd_addr_o = CTL_ADDR; end
      S_WR_CTL: begin
        access = 1'b1; cmd_we_o = 1'b1; cmd_addr_o = CTL_ADDR;
        cmd_wdata_o = word_q | SPD_MASK;
      end
      default: ;
    endcase
  end

  assign cmd_valid_o = access && !pend_q;
  assign wait_en_o   = (state_q == S_WAIT1) || (state_q == S_WAIT2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      pend_q   <= 1'b0;
      unlock_q <= 1'b0;
      ltssm_q  <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      saved_q  <= '0;
      word_q   <= '0;
      code_q   <= ERR_NONE;
      res_q    <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (cmd_valid_o)      pend_q <= 1'b1;
      else if (rsp_valid_i) pend_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_OPEN;
          code_q  <= ERR_NONE;
        end
        S_OPEN: begin
          unlock_q <= 1'b1;
          state_q  <= S_RD_CAP;
        end
        S_RD_CAP: if (rsp_valid_i) begin
          saved_q <= rsp_rdata_i[FLD_W-1:0];
          word_q  <= rsp_rdata_i;
          state_q <= S_WR_CAP;
        end
        S_WR_CAP: if (rsp_valid_i) state_q <= S_TRAIN;
        S_TRAIN: begin
          ltssm_q <= 1'b1;
          state_q <= S_WAIT1;
        end
        S_WAIT1: begin
          if (up_i) state_q <= S_RD_CHK;
          else if (expired_i) begin
            code_q  <= ERR_TRAIN;
            state_q <= S_CLOSE;
          end
        end
        S_RD_CHK: if (rsp_valid_i) begin
          word_q <= rsp_rdata_i;
          if (rsp_rdata_i[FLD_W-1:0] == saved_q) state_q <= S_CLOSE;
          else                                   state_q <= S_WR_RST;
        end
        S_WR_RST: if (rsp_valid_i) state_q <= S_RD_CTL;
        S_RD_CTL: if (rsp_valid_i) begin
          word_q  <= rsp_rdata_i;
          state_q <= S_WR_CTL;
        end
        S_WR_CTL: if (rsp_valid_i) state_q <= S_WAIT2;
        S_WAIT2: begin
          if (up_i) state_q <= S_CLOSE;
          else if (expired_i) begin
            code_q  <= ERR_RETRAIN;
            state_q <= S_CLOSE;
          end
        end
        S_CLOSE: begin
          unlock_q <= 1'b0;
          done_q   <= 1'b1;
          err_q    <= (code_q != ERR_NONE);
          res_q    <= code_q;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ro_wr_en_o = unlock_q;
  assign ltssm_en_o = ltssm_q;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign err_code_o = res_q;

  // R9
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !rsp_valid_i |-> !cmd_valid_o);
endmodule

// File: rtl/link_speed_cap_ctrl.sv
module link_speed_cap_ctrl #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter logic [AW-1:0] CAP_ADDR = 12'h07C,
  parameter logic [AW-1:0] CTL_ADDR = 12'h80C,
  parameter int SPD_BIT = 17,
  parameter int TIMEOUT = 100000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          cfg_req_o,
  output logic          cfg_we_o,
  output logic [AW-1:0] cfg_addr_o,
  output logic [DW-1:0] cfg_wdata_o,
  input  logic          cfg_ready_i,
  input  logic [DW-1:0] cfg_rdata_i,
  output logic          ro_wr_en_o,
  output logic          ltssm_en_o,
  input  logic          link_up_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [1:0]    err_code_o
);
  logic          cmd_valid, cmd_we, rsp_valid, wait_en, up, expired;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata, rsp_rdata;

  lsc_seq #(
    .AW(AW), .DW(DW), .CAP_ADDR(CAP_ADDR), .CTL_ADDR(CTL_ADDR), .SPD_BIT(SPD_BIT)
  ) u_seq (
    .clk_i, .rst_ni, .start_i,
    .rsp_valid_i(rsp_valid), .rsp_rdata_i(rsp_rdata),
    .up_i(up), .expired_i(expired),
    .cmd_valid_o(cmd_valid), .cmd_we_o(cmd_we), .cmd_addr_o(cmd_addr),
    .cmd_wdata_o(cmd_wdata), .wait_en_o(wait_en),
    .ro_wr_en_o, .ltssm_en_o, .busy_o, .done_o, .err_o, .err_code_o
  );

  lsc_cfg_port #(.AW(AW), .DW(DW)) u_port (
    .clk_i, .rst_ni,
    .cmd_valid_i(cmd_valid), .cmd_we_i(cmd_we), .cmd_addr_i(cmd_addr),
    .cmd_wdata_i(cmd_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .cfg_req_o, .cfg_we_o, .cfg_addr_o, .cfg_wdata_o, .cfg_ready_i, .cfg_rdata_i
  );

  lsc_link_wait #(.TIMEOUT(TIMEOUT)) u_wait (
    .clk_i, .rst_ni, .en_i(wait_en), .link_up_i,
    .up_o(up), .expired_o(expired)
  );

  // R2
  wr_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && cfg_we_o |-> ro_wr_en_o);

  // R2
  lock_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ro_wr_en_o && $fell(ro_wr_en_o));

  // R10
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  ltssm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ltssm_en_o |=> ltssm_en_o);

  // R4
  train_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ltssm_en_o) |-> ro_wr_en_o && !cfg_req_o);
endmodule

// File: tb/link_speed_cap_ctrl_test.sv
module link_speed_cap_ctrl_test;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [AW-1:0] CAP = 12'h07C;
  localparam logic [AW-1:0] CTL = 12'h80C;
  localparam int TMO = 50;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
  } item_t;

  logic          clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic          cfg_req_o, cfg_we_o, cfg_ready_i = 1'b0;
  logic [AW-1:0] cfg_addr_o;
  logic [DW-1:0] cfg_wdata_o, cfg_rdata_i = '0;
  logic          ro_wr_en_o, ltssm_en_o, link_up_i = 1'b0;
  logic          busy_o, done_o, err_o;
  logic [1:0]    err_code_o;

  link_speed_cap_ctrl #(.AW(AW), .DW(DW), .CAP_ADDR(CAP), .CTL_ADDR(CTL),
                        .SPD_BIT(17), .TIMEOUT(TMO)) uut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0, done_cnt = 0;
  item_t exp_q[$];
  logic [DW-1:0] cap_reg, ctl_reg;
  int  lat = 0, lat_cnt = 0, up_cd = 0;
  bit  up1, up2, first_run = 1'b1;

  task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      finish_run();
    end
  end

  // config-space model and monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (done_o) done_cnt++;
      if (up_cd > 0) begin
        up_cd--;
        if (up_cd == 0) link_up_i = 1'b1;
      end
      if (cfg_ready_i) begin
        cfg_ready_i = 1'b0;
        lat_cnt = 0;
      end else if (cfg_req_o) begin
        if (lat_cnt == lat) begin
          item_t e;
          cfg_ready_i = 1'b1;
          if (exp_q.size() == 0) begin
            check(1'b0, "R11", "unexpected access addr", DW'(cfg_addr_o), '0);
          end else begin
            e = exp_q.pop_front();
            check(cfg_we_o == e.we, "R3", "access direction", DW'(cfg_we_o), DW'(e.we));
            check(cfg_addr_o == e.addr, "R3", "access address", DW'(cfg_addr_o), DW'(e.addr));
            if (e.we) begin
              check(cfg_wdata_o == e.wdata, "R7", "write data", cfg_wdata_o, e.wdata);
              check(ro_wr_en_o, "R2", "unlock during write", DW'(ro_wr_en_o), 1);
            end
          end
          if (cfg_we_o) begin
            if (cfg_addr_o == CAP) begin
              if (first_run && cfg_wdata_o[3:0] == 4'h1)
                check(!ltssm_en_o, "R4", "ltssm before forced write", DW'(ltssm_en_o), 0);
              if (cap_reg[3:0] != 4'h1 || cfg_wdata_o[3:0] == 4'h1)
                if (cfg_wdata_o[3:0] == 4'h1 && up1) up_cd = 5;
              cap_reg = cfg_wdata_o;
            end else begin
              ctl_reg = cfg_wdata_o;
              link_up_i = 1'b0;
              if (up2) up_cd = 7;
            end
          end else begin
            cfg_rdata_i = (cfg_addr_o == CAP) ? cap_reg : ctl_reg;
          end
        end else begin
          lat_cnt++;
        end
      end
    end
  end

  task automatic push(bit we, logic [AW-1:0] a, logic [DW-1:0] d);
    item_t e;
    e.we = we; e.addr = a; e.wdata = d;
    exp_q.push_back(e);
  endtask

  task automatic run(logic [DW-1:0] cap0, logic [DW-1:0] ctl0, int l,
                     bit u1, bit u2, bit poke);
    logic [3:0] orig;
    logic [1:0] ecode;
    int w;
    orig = cap0[3:0];
    cap_reg = cap0; ctl_reg = ctl0; lat = l; lat_cnt = 0;
    up1 = u1; up2 = u2; up_cd = 0; link_up_i = 1'b0;
    push(1'b0, CAP, '0);
    push(1'b1, CAP, {cap0[DW-1:4], 4'h1});
    if (!u1) ecode = 2'd1;
    else begin
      push(1'b0, CAP, '0);
      if (orig == 4'h1) ecode = 2'd0;
      else begin
        push(1'b1, CAP, {cap0[DW-1:4], orig});
        push(1'b0, CTL, '0);
        push(1'b1, CTL, ctl0 | 32'h0002_0000);
        ecode = u2 ? 2'd0 : 2'd2;
      end
    end
    done_cnt = 0;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    check(busy_o, "R2", "busy after start", DW'(busy_o), 1);
    @(negedge clk_i);
    check(ro_wr_en_o, "R2", "unlocked at sequence begin", DW'(ro_wr_en_o), 1);
    if (poke) begin
      repeat (6) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i) start_i = 1'b0;
    end
    w = 0;
    while (!done_o && w < 2000) begin @(negedge clk_i); w++; end
    check(done_o, "R10", "done pulse seen", DW'(done_o), 1);
    check(err_o == (ecode != 0), "R10", "err with done", DW'(err_o), DW'(ecode != 0));
    check(err_code_o == ecode, ecode == 1 ? "R5" : (ecode == 2 ? "R8" : "R6"),
          "end code", DW'(err_code_o), DW'(ecode));
    check(!ro_wr_en_o, "R2", "locked at done", DW'(ro_wr_en_o), 0);
    repeat (20) @(negedge clk_i);
    check(done_cnt == 1, "R11", "done count", DW'(done_cnt), 1);
    check(exp_q.size() == 0, "R6", "accesses left unperformed", DW'(exp_q.size()), 0);
    check(!busy_o, "R10", "idle after done", DW'(busy_o), 0);
    check(err_code_o == ecode, "R10", "code held", DW'(err_code_o), DW'(ecode));
    check(ltssm_en_o, "R4", "ltssm stays set", DW'(ltssm_en_o), 1);
    exp_q.delete();
    first_run = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(!cfg_req_o && !ro_wr_en_o && !ltssm_en_o && !busy_o && !done_o && !err_o
          && err_code_o == 0, "R1", "reset outputs",
          DW'({cfg_req_o, ro_wr_en_o, ltssm_en_o, busy_o, done_o, err_o, err_code_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    run(32'hABCD_0003, 32'h0001_0040, 0, 1, 1, 0);  // R7 restore path
    run(32'h1234_5671, 32'h0000_0000, 2, 1, 1, 0);  // R6 no restore
    run(32'h0000_0002, 32'h0000_0000, 1, 0, 1, 0);  // R5 first timeout
    run(32'hFFFF_FFF4, 32'h0000_0000, 3, 1, 0, 0);  // R8 second timeout
    run(32'h5555_AAA2, 32'h8000_0001, 1, 1, 1, 1);  // R11 start while busy, R9
    finish_run();
  end
endmodule